// File: doc/BRIEF.md
# I2C Wiper Code Register Target

This block is the digital front end of a 128-step digitally controlled resistor. It listens on an open-drain two-wire serial bus (SCL and SDA), samples both lines with a fast system clock, and keeps one 7-bit wiper code register. A bus master addresses the block with a 7-bit target address chosen by a two-bit strap. Each data byte written after that address loads the register. A read returns the register contents. The register code and a one-cycle update strobe go to the resistor tap decoder.

There is no register-address byte. After one write address, every data byte reloads the wiper until the stop. Reads keep returning the same code for as long as the master acknowledges. The block drives SDA only through an output-enable that pulls the line low. It never stretches the clock. The system clock must run at least ten times faster than SCL.

Top module: `wiper_i2c_target`

## Requirements
- R1: During and after reset the wiper code is 0x40 (midscale of 0x00..0x7F), the update strobe is low and SDA is released (`sda_oe` = 0).
- R2: The first byte after a start holds the address in bits 7..1, most significant bit first, and the R/W bit in bit 0 (0 = write, 1 = read). The address is 0x2E when `addr_sel` is 0 or 3, 0x1F when it is 1 and 0x1E when it is 2. On a match the block pulls SDA low during the ninth SCL clock.
- R3: On an address mismatch the block does not acknowledge. It leaves SDA released and ignores all further bytes until the next start, so the wiper code does not change.
- R4: In a write data byte, bit 7 is ignored and bits 6..0 become the new wiper code. The block acknowledges the byte on its ninth clock. The code changes when that ninth clock goes low.
- R5: After one write address, each further data byte before the stop is acknowledged and loads the wiper again.
- R6: A read byte is 0 in bit 7 followed by wiper bits 6..0, most significant bit first. The block changes SDA only while SCL is low.
- R7: If the master acknowledges a read byte, the block sends the register again. If the master does not acknowledge, the block releases SDA and drives nothing more until the next start.
- R8: A repeated start in the middle of a byte abandons that byte without changing the wiper, and the block then receives a new address.
- R9: A stop returns the block to idle with SDA released. Bytes clocked after a stop without a new start are not acknowledged and do not load the wiper.
- R10: `wiper_upd` is high for exactly one cycle for each loaded data byte. `wiper` changes only in a cycle where `wiper_upd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| addr_sel | input | 2 | Strap that picks the target address |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| wiper | output | 7 | Current wiper code |
| wiper_upd | output | 1 | One-cycle pulse when the wiper code is loaded |

## Verification
The bench sends write bytes with bit 7 set. A block that copied all eight bits, or only the low bits wrongly, would report a different code. It uses all three strap options with both matching and non-matching addresses. A block that compared the wrong bits would acknowledge a foreign address or change the wiper after one. It cuts a write byte in half with a repeated start. A block that committed on partial data would change the code, and one that did not resynchronize would misread the following read address. It also reads several bytes and ends with a NACK, and it clocks a byte after a stop with no start. These catch a block that stops sending after the first byte, keeps driving SDA after the NACK, or accepts data with no address.

// File: rtl/wip_pkg.sv
package wip_pkg;
  // Frame states of the serial target.
  typedef enum logic [2:0] {
    ST_IDLE,   // ignoring the bus until a start
    ST_RX,     // shifting in an address or data byte
    ST_ACK,    // pulling SDA low for the ninth clock
    ST_TX,     // shifting out the register
    ST_MACK    // listening for the master acknowledge
  } wip_state_e;
endpackage

// File: rtl/wip_line_sync.sv
module wip_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~last_q;
  assign fall_o = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/wip_frame_fsm.sv
module wip_frame_fsm
  import wip_pkg::*;
#(
  parameter int DW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          sda_rise,
  input  logic          sda_fall,
  input  logic [6:0]    my_addr,
  input  logic [DW-1:0] cur_code,
  output logic          sda_oe,
  output logic          wr_valid,
  output logic [DW-1:0] wr_code
);
  localparam int BW = DW + 1;
  localparam int CW = $clog2(BW + 1);
  localparam logic [CW-1:0] FULL = CW'(BW);

  wip_state_e     st;
  logic [BW-1:0]  shreg;
  logic [CW-1:0]  cnt;
  logic           data_ph;
  logic           rd_mode;
  logic           mack;

  logic start_ev, stop_ev;
  assign start_ev = scl_lvl & sda_fall;
  assign stop_ev  = scl_lvl & sda_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      shreg    <= '0;
      cnt      <= '0;
      data_ph  <= 1'b0;
      rd_mode  <= 1'b0;
      mack     <= 1'b0;
      wr_valid <= 1'b0;
      wr_code  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start_ev) begin
        st      <= ST_RX;
        cnt     <= '0;
        data_ph <= 1'b0;
      end else if (stop_ev) begin
        st <= ST_IDLE;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[BW-2:0], sda_lvl};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              cnt <= '0;
              if (data_ph) begin
                st <= ST_ACK;
              end else if (shreg[BW-1:1] == my_addr) begin
                st      <= ST_ACK;
                rd_mode <= shreg[0];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (!data_ph) begin
                data_ph <= 1'b1;
                if (rd_mode) begin
                  st    <= ST_TX;
                  shreg <= {1'b0, cur_code};
                  cnt   <= '0;
                end else begin
                  st <= ST_RX;
                end
              end else begin
                wr_valid <= 1'b1;
                wr_code  <= shreg[DW-1:0];
                st       <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == FULL) st <= ST_MACK;
              else shreg <= {shreg[BW-2:0], 1'b0};
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                st    <= ST_TX;
                shreg <= {1'b0, cur_code};
                cnt   <= '0;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe = (st == ST_ACK) | ((st == ST_TX) & ~shreg[BW-1]);

  // R8
  restart_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == ST_RX && cnt == '0 && !data_ph));

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R6
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe != $past(sda_oe)) && !$past(start_ev || stop_ev)) |-> !scl_lvl);
endmodule

// File: rtl/wiper_i2c_target.sv
module wiper_i2c_target #(
  parameter int         CODE_W      = 7,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_MAIN   = 7'h2E,
  parameter logic [6:0] ADDR_ALT1   = 7'h1F,
  parameter logic [6:0] ADDR_ALT2   = 7'h1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_sel,
  output logic              sda_oe,
  output logic [CODE_W-1:0] wiper,
  output logic              wiper_upd
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic [6:0] my_addr;
  logic              wr_valid;
  logic [CODE_W-1:0] wr_code;

  wip_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  wip_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  always_comb begin
    case (addr_sel)
      2'd1:    my_addr = ADDR_ALT1;
      2'd2:    my_addr = ADDR_ALT2;
      default: my_addr = ADDR_MAIN;
    endcase
  end

  wip_frame_fsm #(.DW(CODE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .my_addr(my_addr), .cur_code(wiper),
    .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_code(wr_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper     <= MID_CODE;
      wiper_upd <= 1'b0;
    end else begin
      wiper_upd <= wr_valid;
      if (wr_valid) wiper <= wr_code;
    end
  end

  // R10
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wiper_upd |=> !wiper_upd);

  // R10
  change_needs_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper != $past(wiper)) |-> wiper_upd);
endmodule

// File: tb/wiper_i2c_target_test.sv
module wiper_i2c_target_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [1:0] sel = 2'd0;
  logic       sda_oe;
  logic [6:0] wiper;
  logic       upd;
  wire        sda_line = m_sda & ~sda_oe;

  wiper_i2c_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_sel(sel), .sda_oe(sda_oe), .wiper(wiper), .wiper_upd(upd)
  );

  int checks = 0, errors = 0;
  int upd_cnt = 0, exp_upd = 0, run = 0;
  int bad_run = 0, bad_chg = 0, bad_edge = 0;
  logic [6:0] prev_w = 7'h40;
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  logic [6:0] exp_w;

  always @(negedge clk) begin
    if (rst_n) begin
      if (upd) begin upd_cnt++; run++; if (run > 1) bad_run++; end
      else run = 0;
      if (wiper != prev_w && !upd) bad_chg++;
      if (sda_oe != prev_oe && scl && prev_scl) bad_edge++;
    end
    prev_w = wiper; prev_oe = sda_oe; prev_scl = scl;
  end

  function automatic logic [6:0] addr_of(logic [1:0] s);
    case (s)
      2'd1:    return 7'h1F;
      2'd2:    return 7'h1E;
      default: return 7'h2E;
    endcase
  endfunction

  function automatic logic [7:0] rd_exp(logic [6:0] w);
    return {1'b0, w};
  endfunction

  task automatic wq(int n); repeat (n) @(posedge clk); #1; endtask

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wq(Q); scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_bit(bit b);
    m_sda = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q); ack = ~sda_line; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(bit m_ack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = {b[6:0], sda_line}; wq(Q); scl = 1'b0; wq(Q);
    end
    send_bit(~m_ack);
  endtask

  initial begin
    wq(150000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    logic [7:0] d;
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);

    // R1 reset state
    wq(5);
    chk(wiper == 7'h40, "R1 wiper", wiper, 7'h40);
    chk(!upd && !sda_oe, "R1 idle outputs", {upd, sda_oe}, 0);
    rst_n = 1'b1; wq(10);
    chk(wiper == 7'h40, "R1 after release", wiper, 7'h40);
    exp_w = 7'h40;

    // R2 / R4: write with bit 7 set
    i2c_start;
    send_byte({addr_of(2'd0), 1'b0}, ack); chk(ack, "R2 address ack", ack, 1);
    send_byte(8'hFF, ack); chk(ack, "R4 data ack", ack, 1);
    exp_w = 7'h7F; exp_upd++;
    chk(wiper == exp_w, "R4 msb ignored", wiper, exp_w);
    i2c_stop;

    // R5 multiple data bytes on one address
    i2c_start;
    send_byte({addr_of(2'd0), 1'b0}, ack);
    foreach (d[i]) ; // no-op keeps d declared use simple
    d = 8'h05; send_byte(d, ack); exp_w = d[6:0]; exp_upd++;
    chk(ack && wiper == exp_w, "R5 byte one", wiper, exp_w);
    d = 8'h80; send_byte(d, ack); exp_w = d[6:0]; exp_upd++;
    chk(ack && wiper == exp_w, "R5 byte two", wiper, exp_w);
    d = 8'h33; send_byte(d, ack); exp_w = d[6:0]; exp_upd++;
    chk(ack && wiper == exp_w, "R5 byte three", wiper, exp_w);
    i2c_stop;

    // R6 / R7 repeated reads ending with NACK
    i2c_start;
    send_byte({addr_of(2'd0), 1'b1}, ack); chk(ack, "R2 read address ack", ack, 1);
    recv_byte(1'b1, rb); chk(rb == rd_exp(exp_w), "R6 read one", rb, rd_exp(exp_w));
    recv_byte(1'b1, rb); chk(rb == rd_exp(exp_w), "R7 read two", rb, rd_exp(exp_w));
    recv_byte(1'b0, rb); chk(rb == rd_exp(exp_w), "R7 read three", rb, rd_exp(exp_w));
    m_sda = 1'b1; wq(Q);
    chk(!sda_oe, "R7 released after NACK", sda_oe, 0);
    i2c_stop;

    // R3 mismatched address
    i2c_start;
    send_byte({7'h1F, 1'b0}, ack); chk(!ack, "R3 no ack", ack, 0);
    send_byte(8'h11, ack); chk(!ack, "R3 data ignored", ack, 0);
    chk(wiper == exp_w, "R3 wiper kept", wiper, exp_w);
    i2c_stop;

    // R2 strap options
    sel = 2'd1;
    i2c_start; send_byte({7'h1F, 1'b0}, ack); chk(ack, "R2 alt1 ack", ack, 1);
    send_byte(8'h22, ack); exp_w = 7'h22; exp_upd++; chk(wiper == exp_w, "R2 alt1 write", wiper, exp_w);
    i2c_stop;
    sel = 2'd2;
    i2c_start; send_byte({7'h2E, 1'b0}, ack); chk(!ack, "R3 alt2 rejects main", ack, 0);
    i2c_stop;
    i2c_start; send_byte({7'h1E, 1'b0}, ack); chk(ack, "R2 alt2 ack", ack, 1);
    send_byte(8'hA3, ack); exp_w = 7'h23; exp_upd++; chk(wiper == exp_w, "R2 alt2 write", wiper, exp_w);
    i2c_stop;
    sel = 2'd0;

    // R8 repeated start mid byte
    i2c_start; send_byte({addr_of(2'd0), 1'b0}, ack);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    i2c_start;
    send_byte({addr_of(2'd0), 1'b1}, ack); chk(ack, "R8 new address ack", ack, 1);
    recv_byte(1'b0, rb); chk(rb == rd_exp(exp_w), "R8 partial byte dropped", rb, rd_exp(exp_w));
    i2c_stop;

    // R9 bytes after stop without start
    chk(!sda_oe, "R9 released at stop", sda_oe, 0);
    scl = 1'b0; wq(Q);
    send_byte(8'h09, ack); chk(!ack, "R9 no ack without start", ack, 0);
    chk(wiper == exp_w, "R9 wiper kept", wiper, exp_w);
    i2c_stop;

    // random transactions
    for (int t = 0; t < 24; t++) begin
      logic [6:0] a;
      bit hit;
      int nb;
      sel = 2'($urandom);
      hit = ($urandom % 4) != 0;
      a = hit ? addr_of(sel) : (addr_of(sel) ^ 7'h40);
      nb = 1 + ($urandom % 3);
      i2c_start;
      send_byte({a, 1'b0}, ack); chk(ack == hit, "R2 random address", ack, hit);
      for (int k = 0; k < nb; k++) begin
        d = 8'($urandom);
        send_byte(d, ack);
        if (hit) begin exp_w = d[6:0]; exp_upd++; end
        chk(ack == hit, "R5 random data ack", ack, hit);
        chk(wiper == exp_w, "R4 random wiper", wiper, exp_w);
      end
      i2c_stop;
      i2c_start;
      send_byte({addr_of(sel), 1'b1}, ack);
      recv_byte(1'b0, rb); chk(rb == rd_exp(exp_w), "R6 random read", rb, rd_exp(exp_w));
      i2c_stop;
    end

    wq(20);
    chk(upd_cnt == exp_upd, "R4 strobe count", upd_cnt, exp_upd);
    chk(bad_run == 0, "R10 strobe width", bad_run, 0);
    chk(bad_chg == 0, "R10 change without strobe", bad_chg, 0);
    chk(bad_edge == 0, "R6 SDA moved with SCL high", bad_edge, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule